// File: doc/BRIEF.md
# MOV-ALU Macro-Fusion Pair Detector

This block sits in the decode stage of a processor front end. It receives one decoded instruction slot per cycle and decides whether that slot, together with the instruction in the slot just before it, can be issued as one macro-op. Only one kind of pair is recognised. The older instruction must be a register-to-register MOV. The younger instruction must be a simple ALU operation that writes the same register the MOV wrote and takes its inputs only from registers or an immediate.

A qualifying MOV is held in an internal register for one cycle. The following slot is then compared against it. When the pair fuses, a registered fuse flag rises one cycle after the younger slot is accepted. At the same time the design presents the tags of the older and younger instructions. A fused ALU instruction is never kept as the older half of a later pair. A flush or an empty slot discards the held MOV.

Read-modify-write ALU operations are expected to list their destination register among their sources, as decode presents them.

Top module: `mov_alu_fuser`

## Requirements
- R1: After reset `fuseOut` is 0, and an ALU slot accepted as the first slot after reset does not fuse.
- R2: A slot qualifies as the older half only if all of the following hold: its opcode byte is 0x89 or 0x8B, `inRegReg` is 1, `inHasMem` is 0, `inHasImm` is 0 and source A is valid. Opcodes 0x88 and 0x8A do not qualify. The MOV's source is source A and its destination is `inDst`.
- R3: The younger half must have one of these `inAluOp` codes: ADD=1, ADC=2, AND=3, OR=4, XOR=5, SUB=6, SBB=7, INC=8, DEC=9, NOT=10, SHL/SAL=11, SHR=12, SAR=13. The codes 0 (not an ALU op), 14 and 15 never fuse.
- R4: The younger slot's `inDst` must equal the held MOV's destination register.
- R5: A younger slot with `inHasMem`=1 never fuses. An immediate operand (`inHasImm`=1) does not block fusion.
- R6: At least one valid source of the younger slot must equal the MOV's source or the MOV's destination.
- R7: If both sources of the younger slot are valid and they name the same register, the pair does not fuse.
- R8: Fusion needs the MOV to be the slot accepted directly before the ALU op. A cycle with `inValid`=0 or any other slot in between prevents it.
- R9: The fused ALU slot cannot be the older half of another pair. In a MOV, MOV, ALU sequence, only the second MOV can fuse.
- R10: `flush`=1 discards the held MOV and blocks fusion of the slot presented in the same cycle.
- R11: `fuseOut` is 1 for exactly the one cycle after the younger slot's clock edge. In that cycle `olderIdxOut` and `youngerIdxOut` carry the `inIdx` tags of the MOV and of the ALU op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Pipeline flush; discards the held instruction |
| inValid | input | 1 | Slot holds an instruction this cycle |
| inOpcode | input | 8 | Primary opcode byte |
| inRegReg | input | 1 | Operands are register-to-register (ModRM mod = 11) |
| inAluOp | input | 4 | ALU operation class code (see R3) |
| inDst | input | REG_W | Destination register number |
| inSrcA | input | REG_W | First source register number |
| inSrcAValid | input | 1 | First source present |
| inSrcB | input | REG_W | Second source register number |
| inSrcBValid | input | 1 | Second source present |
| inHasImm | input | 1 | Slot carries an immediate operand |
| inHasMem | input | 1 | Slot has a memory operand |
| inIdx | input | IDX_W | Instruction tag |
| fuseOut | output | 1 | Pair fused (registered) |
| olderIdxOut | output | IDX_W | Tag of the fused MOV |
| youngerIdxOut | output | IDX_W | Tag of the fused ALU op |

## Verification
The bench sends every fusable class and the three non-fusable codes through the same MOV template. A decoder missing a class, or accepting one that should not fuse, gives the wrong flag for that code. It also tests the neighbouring opcodes 0x88 and 0x8A, a MOV with a memory operand, and an ALU op with a memory operand. A design that checks too few opcode bits, or ignores the memory flag on one side, would fuse these.

The bench covers equal source registers, an ALU op that reads neither MOV register, a gap slot, a flush, and a MOV, MOV, ALU sequence. Each of these catches a design that reuses a stale held MOV or compares against the wrong older instruction. In the MOV, MOV, ALU case the reported older tag must be the second MOV. The bench also requires the flag to drop after one cycle, and a second ALU op right after a fused one must not fuse.

// File: rtl/mov_alu_fuse_pkg.sv
package mov_alu_fuse_pkg;

  typedef enum logic [3:0] {
    OP_NONE = 4'd0,
    OP_ADD  = 4'd1,
    OP_ADC  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_SUB  = 4'd6,
    OP_SBB  = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_NOT  = 4'd10,
    OP_SHL  = 4'd11,
    OP_SHR  = 4'd12,
    OP_SAR  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } aluOpE;

  // Compare results: datapath to control
  typedef struct packed {
    logic movQual;
    logic aluClassOk;
    logic aluNoMem;
    logic dstMatch;
    logic readsMov;
    logic srcDistinct;
  } pairFlagsT;

  // Strobes: control to datapath
  typedef struct packed {
    logic loadHeld;
    logic fire;
  } ctrlStrobeT;

  function automatic logic isFusableOp(input logic [3:0] op);
    case (aluOpE'(op))
      OP_ADD, OP_ADC, OP_AND, OP_OR, OP_XOR, OP_SUB, OP_SBB,
      OP_INC, OP_DEC, OP_NOT, OP_SHL, OP_SHR, OP_SAR: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mov_alu_fuse_dp.sv
module mov_alu_fuse_dp
  import mov_alu_fuse_pkg::*;
#(
  parameter int REG_W = 4,
  parameter int IDX_W = 6,
  parameter logic [7:0] MOV_OPC_A = 8'h89,
  parameter logic [7:0] MOV_OPC_B = 8'h8B
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       inOpcode,
  input  logic             inRegReg,
  input  logic [3:0]       inAluOp,
  input  logic [REG_W-1:0] inDst,
  input  logic [REG_W-1:0] inSrcA,
  input  logic             inSrcAValid,
  input  logic [REG_W-1:0] inSrcB,
  input  logic             inSrcBValid,
  input  logic             inHasImm,
  input  logic             inHasMem,
  input  logic [IDX_W-1:0] inIdx,
  input  ctrlStrobeT       strobe,
  output pairFlagsT        flags,
  output logic [IDX_W-1:0] olderIdxOut,
  output logic [IDX_W-1:0] youngerIdxOut
);

  localparam int NUM_SRC = 2;

  logic [REG_W-1:0] heldDst;
  logic [REG_W-1:0] heldSrc;
  logic [IDX_W-1:0] heldIdx;

  logic [NUM_SRC-1:0][REG_W-1:0] srcReg;
  logic [NUM_SRC-1:0]            srcVal;
  logic [NUM_SRC-1:0]            srcHit;

  assign srcReg = {inSrcB, inSrcA};
  assign srcVal = {inSrcBValid, inSrcAValid};

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrcHit
    assign srcHit[g] = srcVal[g] &&
                       ((srcReg[g] == heldSrc) || (srcReg[g] == heldDst));
  end

  always_comb begin
    flags.movQual     = ((inOpcode == MOV_OPC_A) || (inOpcode == MOV_OPC_B)) &&
                        inRegReg && !inHasMem && !inHasImm && inSrcAValid;
    flags.aluClassOk  = isFusableOp(inAluOp);
    flags.aluNoMem    = !inHasMem;
    flags.dstMatch    = (inDst == heldDst);
    flags.readsMov    = |srcHit;
    flags.srcDistinct = !(inSrcAValid && inSrcBValid && (inSrcA == inSrcB));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldDst       <= '0;
      heldSrc       <= '0;
      heldIdx       <= '0;
      olderIdxOut   <= '0;
      youngerIdxOut <= '0;
    end else begin
      if (strobe.loadHeld) begin
        heldDst <= inDst;
        heldSrc <= inSrcA;
        heldIdx <= inIdx;
      end
      if (strobe.fire) begin
        olderIdxOut   <= heldIdx;
        youngerIdxOut <= inIdx;
      end
    end
  end

endmodule

// File: rtl/mov_alu_fuse_ctrl.sv
module mov_alu_fuse_ctrl
  import mov_alu_fuse_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       flush,
  input  logic       inValid,
  input  pairFlagsT  flags,
  output ctrlStrobeT strobe,
  output logic       fuseOut
);

  logic heldValid;
  logic accept;
  logic pairOk;

  assign accept = inValid && !flush;
  assign pairOk = flags.aluClassOk && flags.aluNoMem && flags.dstMatch &&
                  flags.readsMov && flags.srcDistinct;

  always_comb begin
    strobe.fire     = accept && heldValid && pairOk;
    // A fusing slot is an ALU op, never a MOV; keep that explicit
    strobe.loadHeld = accept && flags.movQual && !strobe.fire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldValid <= 1'b0;
      fuseOut   <= 1'b0;
    end else begin
      heldValid <= strobe.loadHeld;
      fuseOut   <= strobe.fire;
    end
  end

endmodule

// File: rtl/mov_alu_fuser.sv
module mov_alu_fuser
  import mov_alu_fuse_pkg::*;
#(
  parameter int REG_W = 4,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             inValid,
  input  logic [7:0]       inOpcode,
  input  logic             inRegReg,
  input  logic [3:0]       inAluOp,
  input  logic [REG_W-1:0] inDst,
  input  logic [REG_W-1:0] inSrcA,
  input  logic             inSrcAValid,
  input  logic [REG_W-1:0] inSrcB,
  input  logic             inSrcBValid,
  input  logic             inHasImm,
  input  logic             inHasMem,
  input  logic [IDX_W-1:0] inIdx,
  output logic             fuseOut,
  output logic [IDX_W-1:0] olderIdxOut,
  output logic [IDX_W-1:0] youngerIdxOut
);

  pairFlagsT  flags;
  ctrlStrobeT strobe;

  mov_alu_fuse_dp #(.REG_W(REG_W), .IDX_W(IDX_W)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .inOpcode     (inOpcode),
    .inRegReg     (inRegReg),
    .inAluOp      (inAluOp),
    .inDst        (inDst),
    .inSrcA       (inSrcA),
    .inSrcAValid  (inSrcAValid),
    .inSrcB       (inSrcB),
    .inSrcBValid  (inSrcBValid),
    .inHasImm     (inHasImm),
    .inHasMem     (inHasMem),
    .inIdx        (inIdx),
    .strobe       (strobe),
    .flags        (flags),
    .olderIdxOut  (olderIdxOut),
    .youngerIdxOut(youngerIdxOut)
  );

  mov_alu_fuse_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .flush  (flush),
    .inValid(inValid),
    .flags  (flags),
    .strobe (strobe),
    .fuseOut(fuseOut)
  );

endmodule

// File: rtl/mov_alu_fuser_checker.sv
module mov_alu_fuser_checker #(
  parameter int REG_W = 4,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             flush,
  input logic             inValid,
  input logic [7:0]       inOpcode,
  input logic [REG_W-1:0] inSrcA,
  input logic             inSrcAValid,
  input logic [REG_W-1:0] inSrcB,
  input logic             inSrcBValid,
  input logic             inHasMem,
  input logic [IDX_W-1:0] inIdx,
  input logic             fuseOut,
  input logic [IDX_W-1:0] youngerIdxOut
);

  AST_OLDER_IS_MOV: assert property (@(posedge clk) disable iff (!rstN)
    fuseOut |-> ($past(inOpcode, 2) == 8'h89 || $past(inOpcode, 2) == 8'h8B)); // R2
  AST_MEM_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inHasMem) |=> !fuseOut); // R5
  AST_SAME_SRC_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (inSrcAValid && inSrcBValid && inSrcA == inSrcB) |=> !fuseOut); // R7
  AST_GAP_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !fuseOut); // R8
  AST_NO_CHAIN: assert property (@(posedge clk) disable iff (!rstN)
    fuseOut |=> !fuseOut); // R9
  AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !fuseOut); // R10
  AST_YOUNGER_TAG: assert property (@(posedge clk) disable iff (!rstN)
    fuseOut |-> (youngerIdxOut == $past(inIdx))); // R11

endmodule

bind mov_alu_fuser mov_alu_fuser_checker #(.REG_W(REG_W), .IDX_W(IDX_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .flush        (flush),
  .inValid      (inValid),
  .inOpcode     (inOpcode),
  .inSrcA       (inSrcA),
  .inSrcAValid  (inSrcAValid),
  .inSrcB       (inSrcB),
  .inSrcBValid  (inSrcBValid),
  .inHasMem     (inHasMem),
  .inIdx        (inIdx),
  .fuseOut      (fuseOut),
  .youngerIdxOut(youngerIdxOut)
);

// File: tb/mov_alu_fuser_tb.sv
module mov_alu_fuser_tb_top;

  localparam int REG_W = 4;
  localparam int IDX_W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inOpcode = '0;
  logic inRegReg = 1'b0;
  logic [3:0] inAluOp = '0;
  logic [REG_W-1:0] inDst = '0, inSrcA = '0, inSrcB = '0;
  logic inSrcAValid = 1'b0, inSrcBValid = 1'b0, inHasImm = 1'b0, inHasMem = 1'b0;
  logic [IDX_W-1:0] inIdx = '0;
  logic fuseOut;
  logic [IDX_W-1:0] olderIdxOut, youngerIdxOut;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  mov_alu_fuser #(.REG_W(REG_W), .IDX_W(IDX_W)) dut_i (.*);

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Present one slot at the falling edge, then move past the rising edge
  task automatic slot(input logic v, input logic [7:0] opc, input logic rr,
                      input logic [3:0] op, input logic [3:0] dst,
                      input logic [3:0] sa, input logic sav,
                      input logic [3:0] sb, input logic sbv,
                      input logic imm, input logic mem, input logic [5:0] idx,
                      input logic fl = 1'b0);
    @(negedge clk);
    inValid = v; inOpcode = opc; inRegReg = rr; inAluOp = op; inDst = dst;
    inSrcA = sa; inSrcAValid = sav; inSrcB = sb; inSrcBValid = sbv;
    inHasImm = imm; inHasMem = mem; inIdx = idx; flush = fl;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    slot(1'b0, 8'h90, 1'b0, 4'd0, 4'd0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 6'd0);
  endtask

  // mov r3 <- r5 (tag 10)
  task automatic movStd();
    slot(1'b1, 8'h89, 1'b1, 4'd0, 4'd3, 4'd5, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 6'd10);
  endtask

  task automatic testReset();
    check(int'(fuseOut), 0, "R1 reset flag");
    slot(1'b1, 8'h01, 1'b1, 4'd1, 4'd3, 4'd3, 1'b1, 4'd5, 1'b1, 1'b0, 1'b0, 6'd1);
    check(int'(fuseOut), 0, "R1 no fuse first slot");
  endtask

  task automatic testClasses();
    for (int op = 0; op < 16; op++) begin
      idle(); movStd();
      slot(1'b1, 8'h01, 1'b1, 4'(op), 4'd3, 4'd3, 1'b1, 4'd5, 1'b1, 1'b0, 1'b0, 6'd11);
      check(int'(fuseOut), (op >= 1 && op <= 13) ? 1 : 0, $sformatf("R3 class %0d", op));
    end
  endtask

  task automatic testMovQual();
    logic [7:0] opcs[4] = '{8'h88, 8'h8A, 8'h8B, 8'h89};
    int exps[4] = '{0, 0, 1, 1};
    for (int i = 0; i < 4; i++) begin
      idle();
      slot(1'b1, opcs[i], 1'b1, 4'd0, 4'd3, 4'd5, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 6'd10);
      slot(1'b1, 8'h01, 1'b1, 4'd1, 4'd3, 4'd3, 1'b1, 4'd5, 1'b1, 1'b0, 1'b0, 6'd11);
      check(int'(fuseOut), exps[i], $sformatf("R2 opcode %0h", opcs[i]));
    end
    idle();
    slot(1'b1, 8'h89, 1'b0, 4'd0, 4'd3, 4'd5, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 6'd10);
    slot(1'b1, 8'h01, 1'b1, 4'd1, 4'd3, 4'd3, 1'b1, 4'd5, 1'b1, 1'b0, 1'b0, 6'd11);
    check(int'(fuseOut), 0, "R2 mov not reg-reg");
    idle();
    slot(1'b1, 8'h8B, 1'b1, 4'd0, 4'd3, 4'd5, 1'b1, 4'd0, 1'b0, 1'b0, 1'b1, 6'd10);
    slot(1'b1, 8'h01, 1'b1, 4'd1, 4'd3, 4'd3, 1'b1, 4'd5, 1'b1, 1'b0, 1'b0, 6'd11);
    check(int'(fuseOut), 0, "R2 mov with memory");
  endtask

  task automatic testOperands();
    idle(); movStd();
    slot(1'b1, 8'h01, 1'b1, 4'd1, 4'd4, 4'd3, 1'b1, 4'd5, 1'b1, 1'b0, 1'b0, 6'd11);
    check(int'(fuseOut), 0, "R4 dst mismatch");
    idle(); movStd();
    slot(1'b1, 8'h01, 1'b0, 4'd1, 4'd3, 4'd3, 1'b1, 4'd0, 1'b0, 1'b0, 1'b1, 6'd11);
    check(int'(fuseOut), 0, "R5 alu memory source");
    idle(); movStd();
    slot(1'b1, 8'h83, 1'b0, 4'd6, 4'd3, 4'd3, 1'b1, 4'd0, 1'b0, 1'b1, 1'b0, 6'd11);
    check(int'(fuseOut), 1, "R5 immediate allowed");
    idle(); movStd();
    slot(1'b1, 8'h01, 1'b1, 4'd1, 4'd3, 4'd7, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 6'd11);
    check(int'(fuseOut), 0, "R6 reads neither");
    idle(); movStd();
    slot(1'b1, 8'h01, 1'b1, 4'd1, 4'd3, 4'd7, 1'b1, 4'd5, 1'b1, 1'b0, 1'b0, 6'd11);
    check(int'(fuseOut), 1, "R6 reads mov source via B");
    idle(); movStd();
    slot(1'b1, 8'h01, 1'b1, 4'd1, 4'd3, 4'd5, 1'b1, 4'd5, 1'b1, 1'b0, 1'b0, 6'd11);
    check(int'(fuseOut), 0, "R7 equal sources r5");
    idle(); movStd();
    slot(1'b1, 8'h01, 1'b1, 4'd1, 4'd3, 4'd3, 1'b1, 4'd3, 1'b1, 1'b0, 1'b0, 6'd11);
    check(int'(fuseOut), 0, "R7 equal sources r3");
  endtask

  task automatic testAdjacency();
    idle(); movStd(); idle();
    slot(1'b1, 8'h01, 1'b1, 4'd1, 4'd3, 4'd3, 1'b1, 4'd5, 1'b1, 1'b0, 1'b0, 6'd11);
    check(int'(fuseOut), 0, "R8 gap slot");
    idle(); movStd();
    slot(1'b1, 8'h01, 1'b1, 4'd1, 4'd9, 4'd9, 1'b1, 4'd8, 1'b1, 1'b0, 1'b0, 6'd12);
    slot(1'b1, 8'h01, 1'b1, 4'd1, 4'd3, 4'd3, 1'b1, 4'd5, 1'b1, 1'b0, 1'b0, 6'd13);
    check(int'(fuseOut), 0, "R8 intervening instruction");
  endtask

  task automatic testChains();
    idle();
    slot(1'b1, 8'h89, 1'b1, 4'd0, 4'd3, 4'd5, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 6'd1);
    slot(1'b1, 8'h8B, 1'b1, 4'd0, 4'd3, 4'd6, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 6'd2);
    check(int'(fuseOut), 0, "R9 mov-mov no fuse");
    slot(1'b1, 8'h01, 1'b1, 4'd1, 4'd3, 4'd3, 1'b1, 4'd6, 1'b1, 1'b0, 1'b0, 6'd3);
    check(int'(fuseOut), 1, "R9 second mov fuses");
    check(int'(olderIdxOut), 2, "R9 older is second mov");
    idle(); movStd();
    slot(1'b1, 8'h01, 1'b1, 4'd1, 4'd3, 4'd3, 1'b1, 4'd5, 1'b1, 1'b0, 1'b0, 6'd11);
    check(int'(fuseOut), 1, "R11 pair fuses");
    check(int'(olderIdxOut), 10, "R11 older tag");
    check(int'(youngerIdxOut), 11, "R11 younger tag");
    slot(1'b1, 8'h01, 1'b1, 4'd5, 4'd3, 4'd3, 1'b1, 4'd5, 1'b1, 1'b0, 1'b0, 6'd12);
    check(int'(fuseOut), 0, "R9 fused alu not older");
    idle();
    check(int'(fuseOut), 0, "R11 single-cycle flag");
  endtask

  task automatic testFlush();
    idle(); movStd();
    slot(1'b1, 8'h01, 1'b1, 4'd1, 4'd3, 4'd3, 1'b1, 4'd5, 1'b1, 1'b0, 1'b0, 6'd11, 1'b1);
    check(int'(fuseOut), 0, "R10 flush same cycle");
    idle(); movStd();
    slot(1'b0, 8'h90, 1'b0, 4'd0, 4'd0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b1);
    slot(1'b1, 8'h01, 1'b1, 4'd1, 4'd3, 4'd3, 1'b1, 4'd5, 1'b1, 1'b0, 1'b0, 6'd11);
    check(int'(fuseOut), 0, "R10 flush clears held mov");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(int'(fuseOut), 0, "R1 flag in reset");
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testClasses();
    testMovQual();
    testOperands();
    testAdjacency();
    testChains();
    testFlush();
    idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule